// File: doc/BRIEF.md
# Width-Expanding Record FIFO

This block sits between a 28-bit serial-link receiver running on a slow write clock and a 64-bit readout engine running on a faster read clock. Each link word carries a 16-bit payload in bits 15..0 and a 4-bit control code in bits 27..24. The code tells the FIFO whether the word opens a record, continues one, closes one, or is filler. Payload words are gathered four at a time into one 64-bit output word. A record that closes on a partial group is padded with zeros and stored at once, so every record occupies a whole number of output words. The last of these words is flagged.

The two clock domains exchange only Gray-coded counters through two-stage synchronisers. These are the write pointer, the read pointer and a count of complete records written. From them the read side derives an empty flag and the number of whole records waiting. The write side derives a full flag and a warning that fires at three quarters of capacity, which upstream logic uses to slow the trigger rate. A flush input in each domain discards every stored word and any half-built group.

Top module: `rec_pack_fifo`

## Requirements
- R1: Within an output word, the earliest payload of its group sits in bits 15..0, the second in bits 31..16, the third in bits 47..32 and the fourth in bits 63..48. A group of four with no close code is stored with `rd_last` low.
- R2: Link codes are 4'h1 (record opens), 4'h2 (record continues) and 4'h3 (record closes). Every other code, including 4'h0 for filler, writes nothing and leaves the group being built unchanged.
- R3: A close code stores the group at once. Unused higher lanes read as zero, and `rd_last` is high on that word only.
- R4: An open code drops any payload words gathered but not yet stored, and starts a new group with itself in bits 15..0.
- R5: `rec_count` equals the number of closed records whose last word has not yet been popped. It falls by one when a word with `rd_last` high is popped.
- R6: While `rd_empty` is low, `rd_data` and `rd_last` show the oldest stored word and hold steady until `rd_en` pops it. Words leave in the order they were stored.
- R7: `wr_almost_full` is high exactly when the stored word count, as seen by the write side, is at least 3/4 of `DEPTH` (48 for the default 64).
- R8: `wr_full` is high when `DEPTH` words are stored. While it is high, every link word is discarded and nothing is overwritten.
- R9: Holding `wflush` and `rflush` together empties the FIFO, clears `rec_count` and drops any partial group. Words written after the release are read back normally.
- R10: After reset, `rd_empty` is high, `rec_count` is zero, and both `wr_full` and `wr_almost_full` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Asynchronous active-low reset, write side |
| wflush | input | 1 | Synchronous flush, write side |
| link_word | input | 28 | Link word: code in 27..24, payload in 15..0, bits 23..16 ignored |
| wr_almost_full | output | 1 | Fill level at or above 3/4 of DEPTH |
| wr_full | output | 1 | DEPTH words stored; link words are dropped |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Asynchronous active-low reset, read side |
| rflush | input | 1 | Synchronous flush, read side |
| rd_en | input | 1 | Pop the head word when not empty |
| rd_data | output | 64 | Head word, four 16-bit lanes |
| rd_last | output | 1 | Head word closes its record |
| rd_empty | output | 1 | No stored word is visible to the read side |
| rec_count | output | $clog2(DEPTH)+1 | Complete records waiting |

## Verification
A stuck or misordered lane counter shows up on the very first word read back: payloads appear in the wrong lanes, or zero padding is missing after a short record. A record counter that drifts from the pointers breaks the link between `rec_count` and `rd_empty` within the few read cycles the synchroniser needs. A wrong fill calculation moves the edges of `wr_almost_full` and `wr_full` off the 48th and 64th stored words, and the next drain then returns too many or too few words. A flush that misses one domain leaves stale words or a nonzero `rec_count` as soon as the synchronisers settle.

// File: rtl/rpf_pkg.sv
package rpf_pkg;
  localparam int LINK_W  = 28;
  localparam int LANE_W  = 16;
  localparam int LANES   = 4;
  localparam int OUT_W   = LANE_W * LANES;
  localparam int LANE_IW = $clog2(LANES);

  typedef enum logic [3:0] {
    CODE_FILL  = 4'h0,
    CODE_OPEN  = 4'h1,
    CODE_CONT  = 4'h2,
    CODE_CLOSE = 4'h3
  } link_code_e;

  typedef struct packed {
    logic             last;
    logic [OUT_W-1:0] data;
  } entry_t;
endpackage

// File: rtl/rpf_gray_sync.sv
module rpf_gray_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_in;
      stage2_q <= stage1_q;
    end
  end

  assign d_out = stage2_q;
endmodule

// File: rtl/rpf_mem.sv
module rpf_mem #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             wclk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  rpf_pkg::entry_t  wentry,
  input  logic [AW-1:0]    raddr,
  output rpf_pkg::entry_t  rentry
);
  rpf_pkg::entry_t store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wentry;
  end

  assign rentry = store[raddr];
endmodule

// File: rtl/rpf_packer.sv
module rpf_packer
  import rpf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 blocked,
  input  logic [3:0]           code,
  input  logic [LANE_W-1:0]    payload,
  output logic                 commit,
  output entry_t               commit_entry,
  output logic [LANE_IW-1:0]   lane
);
  logic [LANE_IW-1:0] lane_q;
  logic [OUT_W-1:0]   acc_q;
  logic               is_data;
  logic               take;
  logic               opens;
  logic               closes;
  logic [LANE_IW-1:0] eff_lane;
  logic [OUT_W-1:0]   eff_acc;
  logic [OUT_W-1:0]   merged;

  function automatic logic [OUT_W-1:0] place(input logic [LANE_W-1:0] w,
                                             input logic [LANE_IW-1:0] slot);
    return OUT_W'(w) << (LANE_W * int'(slot));
  endfunction

  always_comb begin
    opens    = (code == CODE_OPEN);
    closes   = (code == CODE_CLOSE);
    is_data  = opens || closes || (code == CODE_CONT);
    take     = is_data && !blocked;
    eff_lane = opens ? '0 : lane_q;
    eff_acc  = opens ? '0 : acc_q;
    merged   = eff_acc | place(payload, eff_lane);
    commit   = take && (closes || (eff_lane == LANE_IW'(LANES - 1)));
    commit_entry.last = closes;
    commit_entry.data = merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
      acc_q  <= '0;
    end else if (flush) begin
      lane_q <= '0;
      acc_q  <= '0;
    end else if (take) begin
      if (commit) begin
        lane_q <= '0;
        acc_q  <= '0;
      end else begin
        lane_q <= eff_lane + 1'b1;
        acc_q  <= merged;
      end
    end
  end

  assign lane = lane_q;
endmodule

// File: rtl/rec_pack_fifo.sv
module rec_pack_fifo
  import rpf_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                        wclk,
  input  logic                        wrst_n,
  input  logic                        wflush,
  input  logic [LINK_W-1:0]           link_word,
  output logic                        wr_almost_full,
  output logic                        wr_full,
  input  logic                        rclk,
  input  logic                        rrst_n,
  input  logic                        rflush,
  input  logic                        rd_en,
  output logic [OUT_W-1:0]            rd_data,
  output logic                        rd_last,
  output logic                        rd_empty,
  output logic [$clog2(DEPTH):0]      rec_count
);
  localparam int AW       = $clog2(DEPTH);
  localparam int PW       = AW + 1;
  localparam int WARN_LVL = (DEPTH * 3) / 4;

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] fill_of(input logic [PW-1:0] head,
                                            input logic [PW-1:0] tail);
    return head - tail;
  endfunction

  // write domain
  logic [PW-1:0]      wptr_q, wrec_q, wptr_gray, wrec_gray;
  logic [PW-1:0]      rptr_sync, wr_level;
  logic               wr_commit, wr_commit_last;
  logic [LANE_IW-1:0] wr_lane;
  entry_t             wr_entry;
  logic               unused_monitor_bits;

  assign unused_monitor_bits = ^link_word[23:16];

  rpf_packer u_packer (
    .clk          (wclk),
    .rst_n        (wrst_n),
    .flush        (wflush),
    .blocked      (wr_full),
    .code         (link_word[27:24]),
    .payload      (link_word[LANE_W-1:0]),
    .commit       (wr_commit),
    .commit_entry (wr_entry),
    .lane         (wr_lane)
  );

  assign wr_commit_last = wr_entry.last;
  assign wr_level       = fill_of(wptr_q, g2b(rptr_sync));
  assign wr_full        = (wr_level == PW'(DEPTH));
  assign wr_almost_full = (wr_level >= PW'(WARN_LVL));

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wptr_q    <= '0;
      wrec_q    <= '0;
      wptr_gray <= '0;
      wrec_gray <= '0;
    end else if (wflush) begin
      wptr_q    <= '0;
      wrec_q    <= '0;
      wptr_gray <= '0;
      wrec_gray <= '0;
    end else begin
      if (wr_commit) wptr_q <= wptr_q + 1'b1;
      if (wr_commit && wr_commit_last) wrec_q <= wrec_q + 1'b1;
      wptr_gray <= b2g(wptr_q);
      wrec_gray <= b2g(wrec_q);
    end
  end

  // read domain
  logic [PW-1:0] rptr_q, rrec_q, rptr_gray;
  logic [PW-1:0] wptr_sync, wrec_sync;
  logic          rd_pop;
  entry_t        rd_entry;

  assign rd_empty  = rflush || (b2g(rptr_q) == wptr_sync);
  assign rd_pop    = rd_en && !rd_empty;
  assign rd_data   = rd_entry.data;
  assign rd_last   = rd_entry.last;
  assign rec_count = fill_of(g2b(wrec_sync), rrec_q);

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rptr_q    <= '0;
      rrec_q    <= '0;
      rptr_gray <= '0;
    end else if (rflush) begin
      rptr_q    <= '0;
      rrec_q    <= '0;
      rptr_gray <= '0;
    end else begin
      if (rd_pop) rptr_q <= rptr_q + 1'b1;
      if (rd_pop && rd_last) rrec_q <= rrec_q + 1'b1;
      rptr_gray <= b2g(rptr_q);
    end
  end

  // crossings
  rpf_gray_sync #(.W(PW)) u_wptr_sync (
    .clk(rclk), .rst_n(rrst_n), .d_in(wptr_gray), .d_out(wptr_sync));
  rpf_gray_sync #(.W(PW)) u_wrec_sync (
    .clk(rclk), .rst_n(rrst_n), .d_in(wrec_gray), .d_out(wrec_sync));
  rpf_gray_sync #(.W(PW)) u_rptr_sync (
    .clk(wclk), .rst_n(wrst_n), .d_in(rptr_gray), .d_out(rptr_sync));

  rpf_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .wclk   (wclk),
    .we     (wr_commit),
    .waddr  (wptr_q[AW-1:0]),
    .wentry (wr_entry),
    .raddr  (rptr_q[AW-1:0]),
    .rentry (rd_entry)
  );
endmodule

// File: rtl/rpf_chk.sv
module rpf_chk #(
  parameter int PW = 7
) (
  input logic          wclk,
  input logic          wrst_n,
  input logic          wflush,
  input logic          wr_full,
  input logic          wr_almost_full,
  input logic          wr_commit,
  input logic          wr_commit_last,
  input logic [1:0]    wr_lane,
  input logic [PW-1:0] wptr_gray,
  input logic          rclk,
  input logic          rrst_n,
  input logic          rflush,
  input logic          rd_en,
  input logic          rd_empty,
  input logic [63:0]   rd_data,
  input logic [PW-1:0] rec_count
);
  // R8
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    wr_full |-> !wr_commit);

  // R7
  warn_before_full_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    wr_full |-> wr_almost_full);

  // R1
  full_group_lane_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_commit && !wr_commit_last) |-> (wr_lane == 2'd3));

  // R9
  gray_step_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    !$past(wflush) |-> ($countones(wptr_gray ^ $past(wptr_gray)) <= 1));

  // R5
  rec_needs_data_chk: assert property (@(posedge rclk) disable iff (!rrst_n || rflush)
    (rec_count != '0) |-> !rd_empty);

  // R6
  head_hold_chk: assert property (@(posedge rclk) disable iff (!rrst_n || rflush)
    (!rd_empty && !rd_en) |=> $stable(rd_data));
endmodule

bind rec_pack_fifo rpf_chk #(.PW(PW)) u_chk (
  .wclk           (wclk),
  .wrst_n         (wrst_n),
  .wflush         (wflush),
  .wr_full        (wr_full),
  .wr_almost_full (wr_almost_full),
  .wr_commit      (wr_commit),
  .wr_commit_last (wr_commit_last),
  .wr_lane        (wr_lane),
  .wptr_gray      (wptr_gray),
  .rclk           (rclk),
  .rrst_n         (rrst_n),
  .rflush         (rflush),
  .rd_en          (rd_en),
  .rd_empty       (rd_empty),
  .rd_data        (rd_data),
  .rec_count      (rec_count)
);

// File: tb/rec_pack_fifo_tb.sv
module rec_pack_fifo_tb;
  localparam int DEPTH = 64;
  localparam int CW    = $clog2(DEPTH) + 1;

  logic          wclk = 0, rclk = 0;
  logic          wrst_n = 0, rrst_n = 0;
  logic          wflush = 0, rflush = 0;
  logic [27:0]   link_word = 28'h0;
  logic          wr_almost_full, wr_full;
  logic          rd_en = 0;
  logic [63:0]   rd_data;
  logic          rd_last, rd_empty;
  logic [CW-1:0] rec_count;

  int  checks = 0, fails = 0;
  bit  drain_en = 0;
  bit  done = 0;
  logic [64:0] exp_q [$];

  always #5  rclk = ~rclk;
  always #10 wclk = ~wclk;

  rec_pack_fifo #(.DEPTH(DEPTH)) u_dut (
    .wclk(wclk), .wrst_n(wrst_n), .wflush(wflush), .link_word(link_word),
    .wr_almost_full(wr_almost_full), .wr_full(wr_full),
    .rclk(rclk), .rrst_n(rrst_n), .rflush(rflush), .rd_en(rd_en),
    .rd_data(rd_data), .rd_last(rd_last), .rd_empty(rd_empty),
    .rec_count(rec_count));

  task automatic chk(input bit ok, input string tag,
                     input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [3:0] code, input logic [15:0] data);
    @(negedge wclk);
    link_word = {code, 8'hA5, data};
  endtask

  task automatic idle();
    @(negedge wclk);
    link_word = {4'h0, 8'h00, 16'hBEEF};
  endtask

  // driver: sends a record and pushes the packed words it should produce
  task automatic send_rec(input int n, input logic [15:0] base,
                          input int gap, input bit keep);
    logic [63:0] acc = '0;
    for (int i = 0; i < n; i++) begin
      logic [3:0] c;
      if (i == n - 1)  c = 4'h3;
      else if (i == 0) c = 4'h1;
      else             c = 4'h2;
      put(c, base + 16'(i));
      for (int g = 0; g < gap; g++) put((g % 2) ? 4'hF : 4'h0, 16'hDEAD);
      acc = acc | (64'(base + 16'(i)) << (16 * (i % 4)));
      if ((i % 4) == 3 || i == n - 1) begin
        if (keep) exp_q.push_back({(i == n - 1), acc});
        acc = '0;
      end
    end
    idle();
  endtask

  task automatic settle();
    repeat (12) @(negedge rclk);
  endtask

  task automatic drain();
    drain_en = 1;
    wait (exp_q.size() == 0);
    settle();
    drain_en = 0;
    settle();
  endtask

  // monitor: pops expected words and compares with the head of the FIFO
  initial begin
    forever begin
      @(negedge rclk);
      if (drain_en && !rd_empty) begin
        if (exp_q.size() == 0) begin
          chk(0, "R6 word beyond expected", {rd_last, rd_data}, 65'h0);
        end else begin
          logic [64:0] e;
          e = exp_q.pop_front();
          chk({rd_last, rd_data} === e, "R1 R3 R6 word", {rd_last, rd_data}, e);
        end
        rd_en = 1;
      end else begin
        rd_en = 0;
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge wclk);
    chk(rd_empty === 1'b1, "R10 empty", 65'(rd_empty), 65'h1);
    chk(rec_count === '0, "R10 rec_count", 65'(rec_count), 65'h0);
    chk(wr_full === 1'b0, "R10 full", 65'(wr_full), 65'h0);
    chk(wr_almost_full === 1'b0, "R10 warn", 65'(wr_almost_full), 65'h0);
    wrst_n = 1; rrst_n = 1;
    repeat (4) @(negedge wclk);

    // R1 R3: full group, padded groups, single word
    send_rec(4, 16'h1000, 0, 1);
    send_rec(6, 16'h2000, 0, 1);
    send_rec(1, 16'h3000, 0, 1);
    send_rec(9, 16'h4000, 0, 1);
    // R2: filler codes between words change nothing
    send_rec(5, 16'h5000, 2, 1);
    settle();
    // R5: five closed records waiting
    chk(rec_count === CW'(5), "R5 count before drain", 65'(rec_count), 65'd5);
    chk(rd_empty === 1'b0, "R6 not empty", 65'(rd_empty), 65'h0);
    drain();
    chk(rec_count === '0, "R5 count after drain", 65'(rec_count), 65'h0);
    chk(rd_empty === 1'b1, "R6 empty after drain", 65'(rd_empty), 65'h1);

    // R4: open code drops three gathered words
    put(4'h1, 16'h6000); put(4'h2, 16'h6001); put(4'h2, 16'h6002);
    put(4'h1, 16'h7000); put(4'h3, 16'h7001); idle();
    exp_q.push_back({1'b1, 64'h0000_0000_7001_7000});
    settle();
    chk(rec_count === CW'(1), "R4 one record kept", 65'(rec_count), 65'd1);
    drain();

    // R7 R8: fill level edges
    for (int k = 0; k < 47; k++) send_rec(1, 16'(16'h8000 + k), 0, 1);
    chk(wr_almost_full === 1'b0, "R7 warn at 47", 65'(wr_almost_full), 65'h0);
    send_rec(1, 16'h8100, 0, 1);
    chk(wr_almost_full === 1'b1, "R7 warn at 48", 65'(wr_almost_full), 65'h1);
    for (int k = 0; k < 15; k++) send_rec(1, 16'(16'h8200 + k), 0, 1);
    chk(wr_full === 1'b0, "R8 not full at 63", 65'(wr_full), 65'h0);
    send_rec(1, 16'h8300, 0, 1);
    chk(wr_full === 1'b1, "R8 full at 64", 65'(wr_full), 65'h1);
    send_rec(1, 16'hEEEE, 0, 0);
    send_rec(3, 16'hEEF0, 0, 0);
    settle();
    chk(rec_count === CW'(64), "R8 R5 count at full", 65'(rec_count), 65'd64);
    drain();
    chk(rec_count === '0, "R8 nothing extra stored", 65'(rec_count), 65'h0);
    settle();
    chk(wr_almost_full === 1'b0, "R7 warn clears", 65'(wr_almost_full), 65'h0);

    // R9: flush both sides with data and a partial group inside
    send_rec(3, 16'h9000, 0, 0);
    send_rec(2, 16'h9100, 0, 0);
    put(4'h1, 16'h9200); put(4'h2, 16'h9201); idle();
    settle();
    @(negedge wclk);
    wflush = 1; rflush = 1;
    repeat (6) @(negedge wclk);
    wflush = 0; rflush = 0;
    settle();
    chk(rd_empty === 1'b1, "R9 empty after flush", 65'(rd_empty), 65'h1);
    chk(rec_count === '0, "R9 count after flush", 65'(rec_count), 65'h0);
    send_rec(3, 16'hA000, 0, 1);
    settle();
    chk(rec_count === CW'(1), "R9 one record after flush", 65'(rec_count), 65'd1);
    drain();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule